// File: doc/BRIEF.md
# Vertical Output Sync Generator

This block produces the vertical sync for the display side of a scan rate converter. All of its timing is counted in output lines: a one-cycle line strobe advances every counter, and the outgoing sync pulse is held for a fixed number of those lines. The pulse can come from a free-running frame counter. It can also follow the rising edge of the input-side vertical sync after a programmable delay in lines.

When the block follows the input sync, it supports two conversion patterns. In progressive conversion it emits one output sync per input sync. In rate-doubling conversion it adds a second output sync half an input field later. The field length used for that second pulse is the spacing, in lines, between the last two input syncs.

If the input sync disappears for too long, the block falls back to free-running timing. It follows the input again as soon as a sync edge returns. Mode, conversion pattern, frame length and delay are captured into internal shadow copies only at reset and at the start of each output frame, so a setting change never cuts a pulse short. Polarity acts at once.

Top module: `vout_sync_gen`

## Requirements
- R1: During synchronous reset and afterwards, until the first pulse starts, `vsync_out` sits at its inactive level. The inactive level is 0 when `active_low`=0 and 1 when `active_low`=1.
- R2: `active_low`=0 makes the pulse a high level and `active_low`=1 makes it a low level. A change of `active_low` inverts `vsync_out` on the next clock, without waiting for a line strobe.
- R3: A pulse becomes active on the clock after the line strobe that starts it. It stays active for `PULSE_LINES` line strobes (default 2) and ends on the clock after the last of them.
- R4: With `locked_mode`=0 and frame length L, the pulses start on line strobes L-1, 2L-1, 3L-1 and so on. The strobes are counted from 0, where strobe 0 is the first one after reset.
- R5: With `locked_mode`=1 and delay D, a rising edge of `vsync_in` seen between line strobes e and e+1 starts a pulse on strobe e+1+D.
- R6: A new rising edge of `vsync_in` while a delay is still pending restarts the delay from that edge. The earlier edge then produces no pulse.
- R7: With `locked_mode`=1 and `dbl_rate`=0, exactly one pulse is produced per input sync.
- R8: With `locked_mode`=1 and `dbl_rate`=1, a second pulse starts H line strobes after each delayed pulse. H is half, rounded down, of the number of line strobes between the last two input edges. No second pulse is produced before two input edges have been seen, or when H < 3.
- R9: In locked mode, if 2L line strobes pass with no input edge, the block runs on free-running timing. It starts a pulse once L-1 or more strobes have passed since the previous pulse, then every L strobes. A new input edge returns it to locked timing.
- R10: `locked_mode`, `dbl_rate`, `lines_per_frame` and `sync_delay` are sampled at reset and at each frame-starting pulse. A change made mid-frame therefore first affects the frame after the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_stb | input | 1 | One-cycle strobe per output line |
| vsync_in | input | 1 | Input-side vertical sync, rising edge used |
| locked_mode | input | 1 | 1: follow input sync, 0: free-run |
| dbl_rate | input | 1 | 1: two pulses per input sync, 0: one |
| lines_per_frame | input | LW | Free-run frame length in lines (at least 3) |
| sync_delay | input | LW | Delay from input edge to pulse, in lines |
| active_low | input | 1 | Output polarity select |
| vsync_out | output | 1 | Output vertical sync |

## Verification
Free-running timing is swept over every frame length from 3 to 10 in both polarities. This separates the period from the pulse width and the level. Locked runs combine three delays with both conversion patterns, so that the delay offset, the extra half-field pulse and the missing second pulse in the first field can each be told apart. Further dedicated patterns cover a re-triggered delay and a sync that stops and returns, which exercises the fallback entry and exit. A mid-frame change of the frame length shows that it takes effect one frame late.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   // Origin of the start of an output pulse
   typedef enum logic [1:0] {
      TRIG_NONE = 2'd0,
      TRIG_FREE = 2'd1,
      TRIG_LOCK = 2'd2,
      TRIG_HALF = 2'd3
   } trig_e;

   // Shadowed frame settings
   typedef struct packed {
      logic locked;
      logic dbl;
   } mode_t;
endpackage

// File: rtl/vsg_in_edge.sv
module vsg_in_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic vsync_in,
   output logic rise_o
);
   logic synced;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = vsync_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= vsync_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sr_q[i] <= sr_q[i-1];
               end
            end
         end
         assign synced = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         rise_o <= 1'b0;
      end else begin
         prev_q <= synced;
         rise_o <= synced & ~prev_q;
      end
   end
endmodule

// File: rtl/vsg_lock_timer.sv
module vsg_lock_timer #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_stb,
   input  logic          rise,
   input  logic          locked,
   input  logic [LW-1:0] dly,
   input  logic [LW-1:0] lpf,
   output logic          lock_fire,
   output logic          fallback,
   output logic          half_valid,
   output logic [LW-1:0] half_len
);
   localparam int CW = LW + 1;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic          pend_q;
   logic [LW-1:0] dcnt_q;
   logic [CW-1:0] fld_cnt_q;
   logic          seen_q;
   logic [CW-1:0] limit;
   logic [CW-1:0] fld_next;

   assign limit    = {lpf, 1'b0};
   assign fld_next = (fld_cnt_q == CMAX) ? CMAX : fld_cnt_q + CW'(1);
   assign lock_fire = pend_q && line_stb && !rise && (dcnt_q == dly);

   // delay from input edge, restarted by every new edge
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         dcnt_q <= '0;
      end else if (rise) begin
         pend_q <= 1'b1;
         dcnt_q <= '0;
      end else if (pend_q && line_stb) begin
         if (dcnt_q == dly) begin
            pend_q <= 1'b0;
         end else begin
            dcnt_q <= dcnt_q + LW'(1);
         end
      end
   end

   // field length measurement and loss-of-sync detection
   always_ff @(posedge clk) begin
      if (rst) begin
         fld_cnt_q  <= '0;
         seen_q     <= 1'b0;
         half_valid <= 1'b0;
         half_len   <= '0;
         fallback   <= 1'b0;
      end else if (rise) begin
         fld_cnt_q <= '0;
         seen_q    <= 1'b1;
         fallback  <= 1'b0;
         if (seen_q) begin
            half_valid <= 1'b1;
            half_len   <= fld_cnt_q[CW-1:1];
         end
      end else begin
         if (line_stb) begin
            fld_cnt_q <= fld_next;
         end
         if (!locked) begin
            fallback <= 1'b0;
         end else if (line_stb && (fld_next >= limit)) begin
            fallback <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/vsg_frame_timer.sv
module vsg_frame_timer #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_stb,
   input  logic          any_start,
   input  logic [LW-1:0] lpf,
   output logic          frame_due
);
   localparam logic [LW-1:0] FMAX = {LW{1'b1}};

   logic [LW-1:0] fcnt_q;

   assign frame_due = line_stb && (fcnt_q >= lpf - LW'(1));

   always_ff @(posedge clk) begin
      if (rst || any_start) begin
         fcnt_q <= '0;
      end else if (line_stb && fcnt_q != FMAX) begin
         fcnt_q <= fcnt_q + LW'(1);
      end
   end
endmodule

// File: rtl/vsg_half_timer.sv
module vsg_half_timer #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_stb,
   input  logic          enable,
   input  logic          primary,
   input  logic          half_valid,
   input  logic [LW-1:0] half_len,
   output logic          half_fire
);
   localparam logic [LW-1:0] MIN_HALF = LW'(3);

   logic          pend_q;
   logic [LW-1:0] hcnt_q;
   logic [LW-1:0] hlen_q;

   assign half_fire = pend_q && line_stb && !primary &&
                      (hcnt_q == hlen_q - LW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         hcnt_q <= '0;
         hlen_q <= '0;
      end else if (primary) begin
         pend_q <= enable && half_valid && (half_len >= MIN_HALF);
         hcnt_q <= '0;
         hlen_q <= half_len;
      end else if (!enable) begin
         pend_q <= 1'b0;
      end else if (pend_q && line_stb) begin
         if (half_fire) begin
            pend_q <= 1'b0;
         end else begin
            hcnt_q <= hcnt_q + LW'(1);
         end
      end
   end
endmodule

// File: rtl/vsg_pulse_shaper.sv
module vsg_pulse_shaper #(
   parameter int PULSE_LINES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_stb,
   input  logic start,
   input  logic active_low,
   output logic sync_o
);
   localparam int PCW = $clog2(PULSE_LINES + 1);

   logic [PCW-1:0] pcnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt_q <= '0;
      end else if (start) begin
         pcnt_q <= PCW'(PULSE_LINES);
      end else if (line_stb && pcnt_q != '0) begin
         pcnt_q <= pcnt_q - PCW'(1);
      end
   end

   assign sync_o = (pcnt_q != '0) ^ active_low;
endmodule

// File: rtl/vout_sync_gen.sv
module vout_sync_gen
   import vsg_pkg::*;
#(
   parameter int LW          = 12,
   parameter int PULSE_LINES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_stb,
   input  logic          vsync_in,
   input  logic          locked_mode,
   input  logic          dbl_rate,
   input  logic [LW-1:0] lines_per_frame,
   input  logic [LW-1:0] sync_delay,
   input  logic          active_low,
   output logic          vsync_out
);
   generate
      if (LW < 4 || LW > 24) begin : g_bad_lw
         $error("vout_sync_gen: LW out of range");
      end
      if (PULSE_LINES < 1 || PULSE_LINES > 15) begin : g_bad_pw
         $error("vout_sync_gen: PULSE_LINES out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_ss
         $error("vout_sync_gen: SYNC_STAGES out of range");
      end
   endgenerate

   mode_t         sh_mode_q;
   logic [LW-1:0] sh_lpf_q;
   logic [LW-1:0] sh_dly_q;

   logic          rise;
   logic          lock_fire;
   logic          fallback;
   logic          half_valid;
   logic [LW-1:0] half_len;
   logic          frame_due;
   logic          half_fire;
   logic          follow_in;
   logic          primary;
   logic          any_start;
   trig_e         trig;

   assign follow_in = sh_mode_q.locked && !fallback;

   always_comb begin
      trig = TRIG_NONE;
      if (follow_in && lock_fire) begin
         trig = TRIG_LOCK;
      end else if (!follow_in && frame_due) begin
         trig = TRIG_FREE;
      end else if (half_fire) begin
         trig = TRIG_HALF;
      end
   end

   assign primary   = (trig == TRIG_LOCK) || (trig == TRIG_FREE);
   assign any_start = (trig != TRIG_NONE);

   // settings are adopted only at a frame-starting pulse
   always_ff @(posedge clk) begin
      if (rst || primary) begin
         sh_mode_q.locked <= locked_mode;
         sh_mode_q.dbl    <= dbl_rate;
         sh_lpf_q         <= lines_per_frame;
         sh_dly_q         <= sync_delay;
      end
   end

   vsg_in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .vsync_in (vsync_in),
      .rise_o   (rise)
   );

   vsg_lock_timer #(.LW(LW)) u_lock (
      .clk        (clk),
      .rst        (rst),
      .line_stb   (line_stb),
      .rise       (rise),
      .locked     (sh_mode_q.locked),
      .dly        (sh_dly_q),
      .lpf        (sh_lpf_q),
      .lock_fire  (lock_fire),
      .fallback   (fallback),
      .half_valid (half_valid),
      .half_len   (half_len)
   );

   vsg_frame_timer #(.LW(LW)) u_frame (
      .clk       (clk),
      .rst       (rst),
      .line_stb  (line_stb),
      .any_start (any_start),
      .lpf       (sh_lpf_q),
      .frame_due (frame_due)
   );

   vsg_half_timer #(.LW(LW)) u_half (
      .clk        (clk),
      .rst        (rst),
      .line_stb   (line_stb),
      .enable     (follow_in && sh_mode_q.dbl),
      .primary    (primary),
      .half_valid (half_valid),
      .half_len   (half_len),
      .half_fire  (half_fire)
   );

   vsg_pulse_shaper #(.PULSE_LINES(PULSE_LINES)) u_shape (
      .clk        (clk),
      .rst        (rst),
      .line_stb   (line_stb),
      .start      (any_start),
      .active_low (active_low),
      .sync_o     (vsync_out)
   );
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
   parameter int PULSE_LINES = 2
) (
   input logic clk,
   input logic rst,
   input logic line_stb,
   input logic active_low,
   input logic vsync_out
);
   localparam int WCW = $clog2(PULSE_LINES + 2) + 1;
   localparam logic [WCW-1:0] WMAX = {WCW{1'b1}};

   logic           act;
   logic           rst_q;
   logic [WCW-1:0] wcnt_q;

   assign act = vsync_out ^ active_low;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst || !act) begin
         wcnt_q <= '0;
      end else if (line_stb && wcnt_q != WMAX) begin
         wcnt_q <= wcnt_q + WCW'(1);
      end
   end

   // R1: output idle right after reset is released
   always_ff @(posedge clk) begin
      if (!rst && rst_q) begin
         p_reset_idle_r1: assert (vsync_out == active_low)
            else $error("output active right after reset");
      end
   end

   // R2: a polarity change flips the output at once
   p_pol_flip_r2: assert property (@(posedge clk) disable iff (rst)
      (active_low != $past(active_low)) && !$past(line_stb)
      |-> (vsync_out != $past(vsync_out)));

   // R3: pulse edges follow a line strobe
   p_rise_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(act) |-> $past(line_stb));

   p_fall_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(act) |-> $past(line_stb));

   // R3: pulse never shorter than the programmed line count
   p_min_width_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(act) |-> (wcnt_q >= WCW'(PULSE_LINES)));
endmodule

bind vout_sync_gen vsg_checker #(.PULSE_LINES(PULSE_LINES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .line_stb   (line_stb),
   .active_low (active_low),
   .vsync_out  (vsync_out)
);

// File: tb/vout_sync_gen_bench.sv
module vout_sync_gen_bench;
   localparam int LW = 12;
   localparam int PW = 2;
   localparam int NL = 128;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          line_stb = 1'b0;
   logic          vsync_in = 1'b0;
   logic          locked_mode = 1'b0;
   logic          dbl_rate = 1'b0;
   logic [LW-1:0] lines_per_frame = LW'(8);
   logic [LW-1:0] sync_delay = '0;
   logic          active_low = 1'b0;
   logic          vsync_out;

   logic [0:NL-1] exp_v;
   logic [0:NL-1] edge_v;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   vout_sync_gen #(.LW(LW), .PULSE_LINES(PW), .SYNC_STAGES(2)) u_vout_sync_gen (
      .clk             (clk),
      .rst             (rst),
      .line_stb        (line_stb),
      .vsync_in        (vsync_in),
      .locked_mode     (locked_mode),
      .dbl_rate        (dbl_rate),
      .lines_per_frame (lines_per_frame),
      .sync_delay      (sync_delay),
      .active_low      (active_low),
      .vsync_out       (vsync_out)
   );

   task automatic check(input logic act, input logic expv, input string tag, input int ln);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s line %0d: vsync_out=%b expected %b", tag, ln, act, expv);
      end
   endtask

   task automatic set_pulse(input int s);
      for (int i = 0; i < PW; i++) begin
         if (s + i < NL) exp_v[s+i] = 1'b1;
      end
   endtask

   task automatic setup(input logic lk, input logic db, input int lpf, input int dly,
                        input logic pol);
      locked_mode     = lk;
      dbl_rate        = db;
      lines_per_frame = LW'(lpf);
      sync_delay      = LW'(dly);
      active_low      = pol;
      exp_v  = '0;
      edge_v = '0;
      vsync_in = 1'b0;
      line_stb = 1'b0;
      @(negedge clk) rst = 1'b1;
      repeat (3) @(negedge clk);
      check(vsync_out, pol, "R1 in reset", -1);
      rst = 1'b0;
      @(negedge clk);
      check(vsync_out, pol, "R1 after reset", -1);
   endtask

   task automatic run_lines(input int first, input int last, input string tag);
      for (int ln = first; ln <= last; ln++) begin
         @(negedge clk) line_stb = 1'b1;
         @(negedge clk) line_stb = 1'b0;
         vsync_in = edge_v[ln];
         repeat (4) @(negedge clk);
         check(vsync_out, exp_v[ln] ^ active_low, tag, ln);
         @(negedge clk);
      end
   endtask

   initial begin
      // R4 R3 R2: free-running sweep over frame length and polarity
      for (int pol = 0; pol < 2; pol++) begin
         for (int len = 3; len <= 10; len++) begin
            setup(1'b0, 1'b0, len, 0, pol[0]);
            for (int j = 0; j < 40; j++) begin
               if (j >= len - 1 && ((j + 1) % len) < PW) exp_v[j] = 1'b1;
            end
            run_lines(0, 39, "R4 R3 R2 free-run");
         end
      end
      // R2: polarity flip takes effect without a line strobe
      active_low = 1'b0;
      @(negedge clk);
      check(vsync_out, exp_v[39], "R2 flip to high-active", 39);
      active_low = 1'b1;
      @(negedge clk);
      check(vsync_out, ~exp_v[39], "R2 flip to low-active", 39);

      // R5 R7 R8: locked, three delays, both conversion patterns
      for (int db = 0; db < 2; db++) begin
         for (int di = 0; di < 3; di++) begin
            automatic int d = (di == 0) ? 0 : (di == 1) ? 3 : 7;
            setup(1'b1, db[0], 200, d, 1'b0);
            for (int k = 0; k < 4; k++) begin
               automatic int e = 5 + 24 * k;
               edge_v[e] = 1'b1;
               set_pulse(e + 1 + d);
               if (db == 1 && k >= 1) set_pulse(e + 1 + d + 12);
            end
            run_lines(0, 109, db == 1 ? "R5 R8 locked doubling" : "R5 R7 locked progressive");
         end
      end

      // R6: second edge during pending delay restarts it
      setup(1'b1, 1'b0, 200, 7, 1'b0);
      edge_v[10] = 1'b1;
      edge_v[13] = 1'b1;
      set_pulse(21);
      run_lines(0, 39, "R6 delay restart");

      // R9: sync lost and regained
      setup(1'b1, 1'b0, 6, 2, 1'b0);
      edge_v[5] = 1'b1; edge_v[15] = 1'b1; edge_v[25] = 1'b1;
      edge_v[35] = 1'b1; edge_v[70] = 1'b1;
      set_pulse(8); set_pulse(18); set_pulse(28); set_pulse(38);
      set_pulse(48); set_pulse(54); set_pulse(60); set_pulse(66);
      set_pulse(73); set_pulse(83); set_pulse(89); set_pulse(95);
      run_lines(0, 99, "R9 fallback");

      // R10: mid-frame frame-length change applies one frame late
      setup(1'b0, 1'b0, 8, 0, 1'b0);
      set_pulse(7); set_pulse(15); set_pulse(20); set_pulse(25); set_pulse(30);
      run_lines(0, 9, "R10 before change");
      lines_per_frame = LW'(5);
      run_lines(10, 34, "R10 after change");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule